// File: doc/BRIEF.md
# Strided two-dimensional DMA address generator

This block produces the source and destination byte addresses for a memory-to-memory copy of a rectangular window inside a larger framebuffer. One linear element count drives the walk. Elements move in runs of a fixed length. At the end of each run, a side with striding enabled skips forward by its own programmed hole, so the next run starts on the next row of the window.

The run length and the element count are shared by both sides. Each side has its own hole value and its own stride enable. All sizes are counted in elements. The element size in bytes is `1 << wcode`. A hole value `h` moves the address `h` elements at a run boundary, so `h = 1` leaves no gap. All settings are captured when a start is accepted. The data mover reads `active`, `src_addr`, `dst_addr` and `last`, and pulses `advance` once for each beat it completes.

Top module: `stride2d_agen`

## Requirements
- R1: While `rst` is high, and after it is released with no start, `active`, `last` and `done` are 0, and both address outputs are 0.
- R2: An accepted start, seen while `active` is 0, raises `active` on the next cycle with `src_addr = src_base` and `dst_addr = dst_base`.
- R3: On a side with striding disabled, each accepted beat (`active` and `advance` both high, not the final beat) adds `1 << wcode` bytes to that side's address, and the side's hole value has no effect.
- R4: On a side with striding enabled, beat number k of the transfer, counting from 0, adds `hole << wcode` bytes when `(k mod run_len) == run_len - 1`, and `1 << wcode` bytes otherwise. Both sides use the shared `run_len`.
- R5: Striding is enabled per side, so one side can stride while the other walks linearly in the same transfer.
- R6: `last` is high exactly while the address outputs show the final beat of the transfer, and never while `active` is 0.
- R7: The cycle after the final beat is accepted, `done` is high for exactly one cycle and `active` is 0. The address outputs keep the final beat's values.
- R8: While `active` is 0, `advance` has no effect and the addresses hold. A start seen while `active` is 1 is ignored.
- R9: A start with `total_cnt` greater than `MAX_CNT` (default 4095) is rejected: `active` and `done` both stay 0.
- R10: A start with `total_cnt = 0`, or with `run_len = 0` while either side strides, gives `done` on the next cycle and no beat (`active` stays 0). With `run_len = 0` and no striding, the transfer runs linearly.
- R11: Changing any configuration input after a start has been accepted has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a transfer with the current configuration |
| advance | input | 1 | Completes the current beat when `active` is high |
| src_base | input | ADDR_W | Source start byte address |
| dst_base | input | ADDR_W | Destination start byte address |
| wcode | input | WC_W | log2 of the element size in bytes |
| total_cnt | input | CNT_W | Number of elements to move |
| run_len | input | RUN_W | Elements per run, shared by both sides |
| src_hole | input | HOLE_W | Source step at a run end, in elements (1 = no gap) |
| dst_hole | input | HOLE_W | Destination step at a run end, in elements (1 = no gap) |
| src_stride_en | input | 1 | Enables striding on the source side |
| dst_stride_en | input | 1 | Enables striding on the destination side |
| src_addr | output | ADDR_W | Current beat's source byte address |
| dst_addr | output | ADDR_W | Current beat's destination byte address |
| active | output | 1 | A beat is presented |
| last | output | 1 | The presented beat is the final one |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle. The first pair is the final beat of a transfer landing exactly on a run boundary, where the hole jump and the completion compete. The bench provokes this with directed counts that are whole multiples of the run length, including a single-element run. It then judges that the addresses hold the final beat's values while `done` pulses and no jump is taken. The second pair is a start strobe arriving in the same cycle as `advance`, or arriving during a running transfer. Random starts with scrambled configuration are injected on every beat cycle, and the bench judges that the address sequence follows only the configuration captured at the accepted start.

// File: rtl/stride2d_pkg.sv
package stride2d_pkg;
  localparam int unsigned SIDES = 2;
  typedef enum logic [0:0] {SIDE_SRC = 1'b0, SIDE_DST = 1'b1} side_e;
endpackage

// File: rtl/s2d_seq.sv
module s2d_seq #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RUN_W   = 12,
  parameter int unsigned MAX_CNT = 4095
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             advance,
  input  logic [CNT_W-1:0] total_cnt,
  input  logic [RUN_W-1:0] run_len,
  input  logic             stride_any,
  output logic             load,
  output logic             beat,
  output logic             wrap,
  output logic             active,
  output logic             last,
  output logic             done
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CNT);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_C = CNT_W'(2);
  localparam logic [RUN_W-1:0] ONE_R = RUN_W'(1);

  logic [CNT_W-1:0] remain;
  logic [RUN_W-1:0] pos, bnd;
  logic             ok_len, empty;

  assign ok_len = (total_cnt <= MAX_V);
  assign empty  = (total_cnt == '0) || (stride_any && (run_len == '0));
  assign load   = start && !active && ok_len && !empty;
  assign beat   = active && advance;
  assign wrap   = (pos == bnd - ONE_R);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      pos    <= '0;
      bnd    <= '0;
      active <= 1'b0;
      last   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start && ok_len) begin
          if (empty) begin
            done <= 1'b1;
          end else begin
            active <= 1'b1;
            remain <= total_cnt;
            last   <= (total_cnt == ONE_C);
            pos    <= '0;
            bnd    <= run_len;
          end
        end
      end else if (advance) begin
        remain <= remain - ONE_C;
        last   <= (remain == TWO_C);
        pos    <= wrap ? '0 : pos + ONE_R;
        if (remain == ONE_C) begin
          active <= 1'b0;
          last   <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/s2d_side.sv
module s2d_side #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned HOLE_W = 12,
  parameter int unsigned WC_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              stride_en,
  input  logic [HOLE_W-1:0] hole,
  input  logic [WC_W-1:0]   wcode,
  input  logic              beat,
  input  logic              wrap,
  input  logic              last,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  logic              en_q;
  logic [HOLE_W-1:0] hole_q;
  logic [WC_W-1:0]   wc_q;
  logic [ADDR_W-1:0] hole_ext, step;

  assign hole_ext = {{(ADDR_W-HOLE_W){1'b0}}, hole_q};
  assign step     = (en_q && wrap) ? (hole_ext << wc_q) : (ONE_A << wc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      en_q   <= 1'b0;
      hole_q <= '0;
      wc_q   <= '0;
    end else if (load) begin
      addr   <= base;
      en_q   <= stride_en;
      hole_q <= hole;
      wc_q   <= wcode;
    end else if (beat && !last) begin
      addr <= addr + step;
    end
  end
endmodule

// File: rtl/stride2d_agen.sv
module stride2d_agen #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RUN_W   = 12,
  parameter int unsigned HOLE_W  = 12,
  parameter int unsigned WC_W    = 2,
  parameter int unsigned MAX_CNT = 4095
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              advance,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [WC_W-1:0]   wcode,
  input  logic [CNT_W-1:0]  total_cnt,
  input  logic [RUN_W-1:0]  run_len,
  input  logic [HOLE_W-1:0] src_hole,
  input  logic [HOLE_W-1:0] dst_hole,
  input  logic              src_stride_en,
  input  logic              dst_stride_en,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              active,
  output logic              last,
  output logic              done
);
  import stride2d_pkg::*;

  logic load, beat, wrap;
  logic [ADDR_W-1:0] base_a [SIDES];
  logic [ADDR_W-1:0] addr_a [SIDES];
  logic [HOLE_W-1:0] hole_a [SIDES];
  logic              en_a   [SIDES];

  assign base_a[SIDE_SRC] = src_base;
  assign base_a[SIDE_DST] = dst_base;
  assign hole_a[SIDE_SRC] = src_hole;
  assign hole_a[SIDE_DST] = dst_hole;
  assign en_a[SIDE_SRC]   = src_stride_en;
  assign en_a[SIDE_DST]   = dst_stride_en;
  assign src_addr         = addr_a[SIDE_SRC];
  assign dst_addr         = addr_a[SIDE_DST];

  s2d_seq #(.CNT_W(CNT_W), .RUN_W(RUN_W), .MAX_CNT(MAX_CNT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .advance(advance),
    .total_cnt(total_cnt), .run_len(run_len),
    .stride_any(src_stride_en | dst_stride_en),
    .load(load), .beat(beat), .wrap(wrap),
    .active(active), .last(last), .done(done)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    s2d_side #(.ADDR_W(ADDR_W), .HOLE_W(HOLE_W), .WC_W(WC_W)) u_side (
      .clk(clk), .rst(rst), .load(load), .base(base_a[s]),
      .stride_en(en_a[s]), .hole(hole_a[s]), .wcode(wcode),
      .beat(beat), .wrap(wrap), .last(last), .addr(addr_a[s])
    );
  end
endmodule

// File: rtl/s2d_chk.sv
module s2d_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MAX_CNT = 4095
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              advance,
  input logic [CNT_W-1:0]  total_cnt,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              active,
  input logic              last,
  input logic              done
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CNT);

  p_last_in_active_r6: assert property (@(posedge clk) disable iff (rst)
    last |-> active);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_final_beat_r7: assert property (@(posedge clk) disable iff (rst)
    (active && advance && last) |=> (done && !active));

  p_no_early_done_r7: assert property (@(posedge clk) disable iff (rst)
    (active && !(advance && last)) |=> !done);

  p_hold_final_r7: assert property (@(posedge clk) disable iff (rst)
    (active && advance && last) |=> ($stable(src_addr) && $stable(dst_addr)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> ($stable(src_addr) && $stable(dst_addr) && !active));

  p_reject_r9: assert property (@(posedge clk) disable iff (rst)
    (!active && start && (total_cnt > MAX_V)) |=> (!active && !done));
endmodule

bind stride2d_agen s2d_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_chk (
  .clk(clk), .rst(rst), .start(start), .advance(advance), .total_cnt(total_cnt),
  .src_addr(src_addr), .dst_addr(dst_addr), .active(active), .last(last), .done(done)
);

// File: tb/tb_stride2d_agen.sv
module tb_stride2d_agen;
  localparam int MAXC = 4095;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, advance = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [1:0]  wcode = '0;
  logic [15:0] total_cnt = '0;
  logic [11:0] run_len = '0, src_hole = '0, dst_hole = '0;
  logic        src_stride_en = 1'b0, dst_stride_en = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic        active, last, done;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stride2d_agen dut (
    .clk(clk), .rst(rst), .start(start), .advance(advance),
    .src_base(src_base), .dst_base(dst_base), .wcode(wcode),
    .total_cnt(total_cnt), .run_len(run_len), .src_hole(src_hole),
    .dst_hole(dst_hole), .src_stride_en(src_stride_en),
    .dst_stride_en(dst_stride_en), .src_addr(src_addr),
    .dst_addr(dst_addr), .active(active), .last(last), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] step_of(input bit en, input int hole, input int wc,
                                          input int pos, input int bnd);
    if (en && (pos == bnd - 1)) return 32'(hole) << wc;
    return 32'd1 << wc;
  endfunction

  task automatic scramble();
    src_base  = $urandom;
    dst_base  = $urandom;
    wcode     = 2'($urandom);
    total_cnt = 16'($urandom % 50);
    run_len   = 12'($urandom % 8);
    src_hole  = 12'($urandom % 9);
    dst_hole  = 12'($urandom % 9);
    src_stride_en = 1'($urandom);
    dst_stride_en = 1'($urandom);
  endtask

  task automatic run_xfer(input logic [31:0] sb, input logic [31:0] db, input int wc,
                          input int cnt, input int bnd, input bit se, input bit de,
                          input int sh, input int dh);
    logic [31:0] es, ed;
    int pos, rem;
    string tag;
    tag = (se || de) ? ((se ^ de) ? "R5/R11" : "R4/R11") : "R3/R11";
    @(negedge clk);
    src_base = sb; dst_base = db; wcode = 2'(wc); total_cnt = 16'(cnt);
    run_len = 12'(bnd); src_hole = 12'(sh); dst_hole = 12'(dh);
    src_stride_en = se; dst_stride_en = de;
    start = 1'b1; advance = 1'($urandom);
    @(negedge clk);
    start = 1'b0;
    scramble();
    if (cnt > MAXC) begin
      chk("R9 active", 32'(active), 0);
      chk("R9 done", 32'(done), 0);
      return;
    end
    if (cnt == 0 || (bnd == 0 && (se || de))) begin
      chk("R10 done", 32'(done), 1);
      chk("R10 active", 32'(active), 0);
      return;
    end
    chk("R2 src", src_addr, sb);
    chk("R2 dst", dst_addr, db);
    es = sb; ed = db; pos = 0; rem = cnt;
    while (rem > 0) begin
      bit adv;
      chk("R2 active", 32'(active), 1);
      chk({tag, " src"}, src_addr, es);
      chk({tag, " dst"}, dst_addr, ed);
      chk("R6 last", 32'(last), 32'(rem == 1));
      adv = ($urandom % 3) != 0;
      advance = adv;
      start = (($urandom % 4) == 0);
      scramble();
      @(negedge clk);
      if (adv) begin
        rem--;
        if (rem > 0) begin
          es = es + step_of(se, sh, wc, pos, bnd);
          ed = ed + step_of(de, dh, wc, pos, bnd);
          pos = (pos == bnd - 1) ? 0 : pos + 1;
        end
      end
    end
    start = 1'b0;
    chk("R7 done", 32'(done), 1);
    chk("R7 active", 32'(active), 0);
    chk("R7 src hold", src_addr, es);
    chk("R7 dst hold", dst_addr, ed);
    advance = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk("R7 done one cycle", 32'(done), 0);
      chk("R8 src idle", src_addr, es);
      chk("R8 dst idle", dst_addr, ed);
      chk("R8 active idle", 32'(active), 0);
    end
    advance = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 active", 32'(active), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 src", src_addr, 0);
    rst = 1'b0;
    advance = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle active", 32'(active), 0);
    chk("R1 last", 32'(last), 0);
    chk("R1 dst", dst_addr, 0);
    advance = 1'b0;
    // directed corner cases
    run_xfer(32'h1000, 32'h8000, 2, 12, 4, 1'b0, 1'b0, 7, 7);   // R3 linear, holes ignored
    run_xfer(32'h1000, 32'h8000, 1, 12, 4, 1'b1, 1'b1, 3, 5);   // R4 ends on run boundary
    run_xfer(32'h2000, 32'h9000, 0, 9, 3, 1'b1, 1'b1, 1, 1);    // R4 hole 1 = no gap
    run_xfer(32'h3000, 32'hA000, 2, 10, 3, 1'b1, 1'b0, 4, 9);   // R5 source only
    run_xfer(32'h3000, 32'hA000, 0, 10, 2, 1'b0, 1'b1, 9, 6);   // R5 destination only
    run_xfer(32'h4000, 32'hB000, 1, 1, 1, 1'b1, 1'b1, 8, 8);    // single beat on boundary
    run_xfer(32'h4000, 32'hB000, 1, 5, 1, 1'b1, 1'b1, 2, 3);    // run of one element
    run_xfer(32'h5000, 32'hC000, 0, 0, 3, 1'b1, 1'b1, 2, 2);    // R10 zero count
    run_xfer(32'h5000, 32'hC000, 0, 6, 0, 1'b1, 1'b0, 2, 2);    // R10 zero run with stride
    run_xfer(32'h5000, 32'hC000, 2, 6, 0, 1'b0, 1'b0, 2, 2);    // R10 zero run linear
    run_xfer(32'h6000, 32'hD000, 0, MAXC + 1, 3, 1'b1, 1'b1, 2, 2); // R9 reject
    run_xfer(32'h6000, 32'hD000, 0, MAXC, 64, 1'b1, 1'b1, 3, 2);    // maximum accepted
    // constrained random
    for (int i = 0; i < 40; i++) begin
      int bnd;
      bnd = 1 + ($urandom % 6);
      run_xfer($urandom, $urandom, $urandom % 3, 1 + ($urandom % 40), bnd,
               1'($urandom), 1'($urandom), 1 + ($urandom % 5), 1 + ($urandom % 5));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule